// File: doc/BRIEF.md
# Write-Buffer Entry Timeout Tracker

This block watches every slot of a small write buffer and decides when a held slot has waited long enough to be pushed out. It does not give each slot its own wide counter. One free-running counter is shared by all slots, and a selectable bit of that counter acts as a coarse timebase. Each slot keeps only a two-step age. The age moves forward whenever the chosen timebase bit changes value. A slot is reported as expired once its age has moved forward twice since it was allocated. Because a slot can be allocated at any phase of the timebase, the wait it actually sees lies between one and two timebase intervals.

The surrounding buffer logic signals four events per slot: a slot was filled, a store merged into it, it was flagged as marked, or it was drained. Three configuration inputs control the timing. The interval select chooses the timebase bit. A long-timeout disable decides whether marked slots use the slowest timebase or the programmed one. A merge-keep control decides whether a merge restarts the slot's age. The outputs are the per-slot expired vector and the index of the lowest expired slot, together with a flag that says whether any slot is expired.

Top module: `wbto_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `expired_o` is all zeros, `exp_any_o` is 0 and `exp_idx_o` is 0. The shared counter restarts from 0.
- R2: The programmed timebase is counter bit `cfg_sel_i + BASE_BIT` (11 by default). With T = 2^(cfg_sel_i + BASE_BIT), an age step happens in every cycle whose counter value is a nonzero multiple of T. The counter value is the number of cycles since reset. A slot allocated in the cycle with counter value c0 reports expired after the clock edge that ends the second such cycle after c0. This is between T+1 and 2T cycles after the allocation cycle.
- R3: Allocation makes the slot valid, sets its age to zero and records the marked strobe of that cycle. Allocation has priority over a release, a merge or a timebase step that arrives in the same cycle.
- R4: The age saturates at its expired value. An expired slot stays expired until it is allocated, released, or restarted by a merge.
- R5: When `cfg_merge_keep_i` is 0, a merge into a valid slot sets its age back to zero. When it is 1, a merge leaves the age unchanged and the slot keeps aging. A merge into a slot that is not valid has no effect.
- R6: When `cfg_long_off_i` is 0, a marked slot ages on the slowest timebase, bit `MAX_SEL + BASE_BIT` (18 by default). When it is 1, a marked slot ages on the programmed timebase like any other slot.
- R7: A marked strobe on a valid slot flags that slot as marked from the next cycle onward. A marked strobe on a slot that is not valid is ignored.
- R8: A release without allocation makes the slot invalid and clears its age. A slot that is not valid never reports expired.
- R9: `exp_any_o` is 1 exactly when some bit of `expired_o` is 1. When it is 1, `exp_idx_o` is the lowest set position of `expired_o`. Otherwise `exp_idx_o` is 0.
- R10: In a cycle where `cfg_sel_i` differs from its value in the previous cycle, the programmed timebase produces no age step. After reset, the previous value is taken to be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | N_ENTRIES | Per-slot allocate strobe |
| merge_i | input | N_ENTRIES | Per-slot merged-store strobe |
| mark_i | input | N_ENTRIES | Per-slot marked flag strobe |
| release_i | input | N_ENTRIES | Per-slot drain strobe |
| cfg_sel_i | input | SEL_W | Timebase select, bit = select + BASE_BIT |
| cfg_long_off_i | input | 1 | 1: marked slots use the programmed timebase |
| cfg_merge_keep_i | input | 1 | 1: merges do not restart the age |
| expired_o | output | N_ENTRIES | Per-slot expired flag |
| exp_any_o | output | 1 | Some slot is expired |
| exp_idx_o | output | IDX_W | Lowest expired slot index |

## Verification
Every slot event and every timebase step takes effect at the single clock edge that ends the cycle in which it is presented. The age step for a cycle is decided from the counter value in that same cycle. So `expired_o` changes one edge after the cycle holding the second qualifying counter value. `exp_any_o` and `exp_idx_o` follow in that same cycle, because they are derived without registers from the slot state. The bench keeps its own cycle count, which equals the counter value. Before each edge it applies the requirements to compute the next slot state, then compares all three outputs 2 ns after that edge. The measured allocate-to-expire latencies are also checked against the exact multiple-of-T arithmetic.

// File: rtl/wbto_pkg.sv
package wbto_pkg;

    // Age of one slot; value 3 is never produced.
    typedef enum logic [1:0] {
        AGE_FRESH = 2'd0,
        AGE_HALF  = 2'd1,
        AGE_DONE  = 2'd2
    } age_e;

    // Registered state of one slot.
    typedef struct packed {
        logic valid;
        logic marked;
        age_e age;
    } slot_t;

    // Per-slot events of one cycle.
    typedef struct packed {
        logic alloc;
        logic merge;
        logic mark;
        logic rel;
    } slot_cmd_t;

    // Shared timing controls.
    typedef struct packed {
        logic long_off;
        logic merge_keep;
    } slot_cfg_t;

    // What a slot does in a cycle, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_FILL = 2'd1,
        ACT_DROP = 2'd2,
        ACT_LIVE = 2'd3
    } slot_act_e;

    localparam slot_t SLOT_EMPTY = '{valid: 1'b0, marked: 1'b0, age: AGE_FRESH};

    function automatic age_e age_step(input age_e cur);
        age_e nxt;
        unique case (cur)
            AGE_FRESH: nxt = AGE_HALF;
            AGE_HALF:  nxt = AGE_DONE;
            default:   nxt = AGE_DONE;
        endcase
        return nxt;
    endfunction

    function automatic slot_act_e slot_action(input slot_cmd_t cmd, input logic valid);
        slot_act_e act;
        if (cmd.alloc)      act = ACT_FILL;
        else if (cmd.rel)   act = ACT_DROP;
        else if (valid)     act = ACT_LIVE;
        else                act = ACT_HOLD;
        return act;
    endfunction

    function automatic logic slot_done(input slot_t s);
        return s.valid && (s.age == AGE_DONE);
    endfunction

endpackage

// File: rtl/wbto_tick_gen.sv
module wbto_tick_gen
    import wbto_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int SEL_W    = 3,
    parameter int BASE_BIT = 11,
    parameter int MAX_SEL  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_prog_o,
    output logic             tick_max_o
);
    localparam int TAP_W   = $clog2(CNT_W);
    localparam int MAX_TAP = BASE_BIT + MAX_SEL;
    localparam int N_LANES = 2;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [TAP_W-1:0] lane_tap [N_LANES];
    logic [N_LANES-1:0] lane_cur;
    logic [N_LANES-1:0] lane_prev_q;
    logic [N_LANES-1:0] lane_chg;
    logic sel_steady;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            sel_q <= sel_i;
        end
    end

    assign sel_steady  = (sel_q == sel_i);
    assign lane_tap[0] = TAP_W'(BASE_BIT) + TAP_W'(sel_i);
    assign lane_tap[1] = TAP_W'(MAX_TAP);

    // One edge detector per timebase: lane 0 programmed, lane 1 slowest.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_cur[g] = cnt_q[lane_tap[g]];

        always_ff @(posedge clk) begin
            if (rst) lane_prev_q[g] <= 1'b0;
            else     lane_prev_q[g] <= lane_cur[g];
        end

        assign lane_chg[g] = lane_cur[g] ^ lane_prev_q[g];
    end

    assign tick_prog_o = lane_chg[0] && sel_steady;
    assign tick_max_o  = lane_chg[1];

endmodule

// File: rtl/wbto_slot.sv
module wbto_slot
    import wbto_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_cmd_t cmd_i,
    input  slot_cfg_t cfg_i,
    input  logic      tick_prog_i,
    input  logic      tick_max_i,
    output logic      expired_o
);
    slot_t cur_q;
    slot_t nxt;
    logic  use_max;
    logic  tick;

    assign use_max = cur_q.marked && !cfg_i.long_off;
    assign tick    = use_max ? tick_max_i : tick_prog_i;

    always_comb begin
        nxt = cur_q;
        unique case (slot_action(cmd_i, cur_q.valid))
            ACT_FILL: begin
                nxt.valid  = 1'b1;
                nxt.marked = cmd_i.mark;
                nxt.age    = AGE_FRESH;
            end
            ACT_DROP: nxt = SLOT_EMPTY;
            ACT_LIVE: begin
                nxt.marked = cur_q.marked | cmd_i.mark;
                if (cmd_i.merge && !cfg_i.merge_keep) nxt.age = AGE_FRESH;
                else if (tick)                        nxt.age = age_step(cur_q.age);
            end
            default: nxt = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= SLOT_EMPTY;
        else     cur_q <= nxt;
    end

    assign expired_o = slot_done(cur_q);

endmodule

// File: rtl/wbto_lowest.sv
module wbto_lowest #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wbto_tracker.sv
module wbto_tracker
    import wbto_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 3,
    parameter int BASE_BIT  = 11,
    parameter int MAX_SEL   = 7,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ENTRIES-1:0] alloc_i,
    input  logic [N_ENTRIES-1:0] merge_i,
    input  logic [N_ENTRIES-1:0] mark_i,
    input  logic [N_ENTRIES-1:0] release_i,
    input  logic [SEL_W-1:0]     cfg_sel_i,
    input  logic                 cfg_long_off_i,
    input  logic                 cfg_merge_keep_i,
    output logic [N_ENTRIES-1:0] expired_o,
    output logic                 exp_any_o,
    output logic [IDX_W-1:0]     exp_idx_o
);
    logic      tick_prog;
    logic      tick_max;
    slot_cfg_t cfg;

    assign cfg.long_off   = cfg_long_off_i;
    assign cfg.merge_keep = cfg_merge_keep_i;

    wbto_tick_gen #(
        .CNT_W    (CNT_W),
        .SEL_W    (SEL_W),
        .BASE_BIT (BASE_BIT),
        .MAX_SEL  (MAX_SEL)
    ) u_tick (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (cfg_sel_i),
        .tick_prog_o (tick_prog),
        .tick_max_o  (tick_max)
    );

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_slot
        slot_cmd_t cmd;
        assign cmd.alloc = alloc_i[e];
        assign cmd.merge = merge_i[e];
        assign cmd.mark  = mark_i[e];
        assign cmd.rel   = release_i[e];

        wbto_slot u_slot (
            .clk         (clk),
            .rst         (rst),
            .cmd_i       (cmd),
            .cfg_i       (cfg),
            .tick_prog_i (tick_prog),
            .tick_max_i  (tick_max),
            .expired_o   (expired_o[e])
        );
    end

    wbto_lowest #(
        .N     (N_ENTRIES),
        .IDX_W (IDX_W)
    ) u_lowest (
        .req_i (expired_o),
        .any_o (exp_any_o),
        .idx_o (exp_idx_o)
    );

endmodule

// File: rtl/wbto_tracker_chk.sv
module wbto_tracker_chk #(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N_ENTRIES-1:0] alloc_i,
    input logic [N_ENTRIES-1:0] merge_i,
    input logic [N_ENTRIES-1:0] release_i,
    input logic                 cfg_merge_keep_i,
    input logic [N_ENTRIES-1:0] expired_o,
    input logic                 exp_any_o,
    input logic [IDX_W-1:0]     exp_idx_o
);
    logic [N_ENTRIES-1:0] below_mask;
    logic [N_ENTRIES-1:0] restart;
    logic [N_ENTRIES-1:0] keep_set;

    assign below_mask = (N_ENTRIES'(1) << exp_idx_o) - N_ENTRIES'(1);
    assign restart    = alloc_i | release_i | (merge_i & {N_ENTRIES{~cfg_merge_keep_i}});
    assign keep_set   = expired_o & ~restart;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (expired_o == '0)); // R1

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
        exp_any_o |-> (expired_o[exp_idx_o] && ((expired_o & below_mask) == '0))); // R9

    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (expired_o == '0) |-> (!exp_any_o && exp_idx_o == '0)); // R9

    AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (rst)
        (|alloc_i) |=> ((expired_o & $past(alloc_i)) == '0)); // R3

    AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (rst)
        (|(release_i & ~alloc_i)) |=> ((expired_o & $past(release_i & ~alloc_i)) == '0)); // R8

    AST_MERGE_RESTART: assert property (@(posedge clk) disable iff (rst)
        ((|merge_i) && !cfg_merge_keep_i) |=> ((expired_o & $past(merge_i)) == '0)); // R5

    AST_EXPIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|keep_set) |=> (($past(keep_set) & ~expired_o) == '0)); // R4

endmodule

bind wbto_tracker wbto_tracker_chk #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .alloc_i          (alloc_i),
    .merge_i          (merge_i),
    .release_i        (release_i),
    .cfg_merge_keep_i (cfg_merge_keep_i),
    .expired_o        (expired_o),
    .exp_any_o        (exp_any_o),
    .exp_idx_o        (exp_idx_o)
);

// File: tb/tb_wbto_tracker.sv
module tb_wbto_tracker;
    localparam int N    = 8;
    localparam int SW   = 3;
    localparam int BASE = 2;
    localparam int MAXS = 7;
    localparam int IW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] alloc = '0, merge = '0, mark = '0, rel = '0;
    logic [SW-1:0] sel = '0;
    logic long_off = 1'b0, keep = 1'b0;
    logic [N-1:0] expired;
    logic any_exp;
    logic [IW-1:0] idx;

    always #5 clk = ~clk;

    wbto_tracker #(.N_ENTRIES(N), .CNT_W(32), .SEL_W(SW), .BASE_BIT(BASE), .MAX_SEL(MAXS)) dut (
        .clk(clk), .rst(rst), .alloc_i(alloc), .merge_i(merge), .mark_i(mark), .release_i(rel),
        .cfg_sel_i(sel), .cfg_long_off_i(long_off), .cfg_merge_keep_i(keep),
        .expired_o(expired), .exp_any_o(any_exp), .exp_idx_o(idx)
    );

    int checks = 0;
    int fails = 0;
    int bcnt = 0;
    int sel_prev = 0;
    bit mv[N];
    bit mm[N];
    int ma[N];
    string cur_req = "R2";

    function automatic int per(input int s);
        return 1 << (s + BASE);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [N-1:0] e;
        logic ea;
        int ei;
        e = '0; ea = 1'b0; ei = 0;
        for (int i = 0; i < N; i++) e[i] = mv[i] && (ma[i] == 2);
        for (int i = N - 1; i >= 0; i--) if (e[i]) begin ea = 1'b1; ei = i; end
        chk(expired == e && any_exp == ea && idx == IW'(ei), cur_req, "expired/any/idx",
            {expired, any_exp, idx}, {e, ea, IW'(ei)});
    endtask

    // One clock cycle: model the requirements, clock, compare.
    task automatic step();
        bit tp, tm, tk;
        bit nv[N];
        bit nm[N];
        int na[N];
        tp = (int'(sel) == sel_prev) && bcnt != 0 && (bcnt % per(int'(sel))) == 0;
        tm = bcnt != 0 && (bcnt % per(MAXS)) == 0;
        for (int i = 0; i < N; i++) begin
            nv[i] = mv[i]; nm[i] = mm[i]; na[i] = ma[i];
            if (alloc[i]) begin
                nv[i] = 1; nm[i] = mark[i]; na[i] = 0;
            end else if (rel[i]) begin
                nv[i] = 0; nm[i] = 0; na[i] = 0;
            end else if (mv[i]) begin
                nm[i] = mm[i] | mark[i];
                tk = (mm[i] && !long_off) ? tm : tp;
                if (merge[i] && !keep) na[i] = 0;
                else if (tk && ma[i] < 2) na[i] = ma[i] + 1;
            end
        end
        @(posedge clk);
        #2;
        for (int i = 0; i < N; i++) begin mv[i] = nv[i]; mm[i] = nm[i]; ma[i] = na[i]; end
        bcnt++;
        sel_prev = int'(sel);
        alloc = '0; merge = '0; mark = '0; rel = '0;
        check_outputs();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    // Allocate slot e and count steps until it is expired; compare with arithmetic.
    task automatic measure(input int e, input bit mk, input int p, input string req);
        int c0, c2, lat, f;
        c0 = bcnt;
        alloc[e] = 1'b1;
        mark[e] = mk;
        step();
        lat = 1;
        while (!expired[e] && lat < 3 * p + 4) begin
            step();
            lat++;
        end
        f = (c0 / p + 1) * p;
        c2 = f + p;
        chk(lat == c2 - c0 + 1, req, "alloc-to-expire steps", lat, c2 - c0 + 1);
        chk(lat - 1 > p && lat - 1 <= 2 * p, req, "expiry window 1x..2x", lat - 1, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mv[i] = 0; mm[i] = 0; ma[i] = 0; end
        repeat (3) @(posedge clk);
        #2;
        chk(expired == '0 && !any_exp && idx == '0, "R1", "outputs in reset",
            {expired, any_exp, idx}, 0);
        rst = 1'b0;
        bcnt = 0;
        sel_prev = 0;
        cur_req = "R1";
        step();

        // R2: sweep select and allocation phase
        cur_req = "R2";
        for (int s = 0; s < 8; s++) begin
            int p;
            int nph;
            p = per(s);
            sel = SW'(s);
            idle(2);
            nph = (s < 4) ? p : 2;
            for (int ph = 0; ph < nph; ph++) begin
                int tgt;
                tgt = (s < 4) ? ph : (ph == 0 ? 0 : p - 1);
                while ((bcnt % p) != tgt) step();
                measure(s, 1'b0, p, "R2");
                rel[s] = 1'b1;
                step();
            end
        end

        // R6: marked slots on the slowest timebase unless disabled
        cur_req = "R6";
        sel = '0;
        idle(2);
        long_off = 1'b0;
        measure(1, 1'b1, per(MAXS), "R6");
        rel[1] = 1'b1; step();
        long_off = 1'b1;
        measure(1, 1'b1, per(0), "R6");
        rel[1] = 1'b1; step();
        long_off = 1'b0;

        // R7: late mark on valid slot, mark on invalid slot ignored
        cur_req = "R7";
        alloc[2] = 1'b1; step();
        mark[2] = 1'b1; step();
        idle(2 * per(0) + 2);
        chk(!expired[2], "R7", "late-marked slot still aging slowly", expired[2], 0);
        rel[2] = 1'b1; step();
        mark[4] = 1'b1; step();
        alloc[4] = 1'b1; step();
        idle(2 * per(0) + 1);
        chk(expired[4], "R7", "mark on empty slot ignored", expired[4], 1);
        rel[4] = 1'b1; step();

        // R5: merge restarts age unless kept
        cur_req = "R5";
        sel = SW'(1);
        idle(2);
        alloc[3] = 1'b1; step();
        for (int k = 0; k < 10; k++) begin
            idle(5);
            merge[3] = 1'b1; step();
        end
        chk(!expired[3], "R5", "merges hold off expiry", expired[3], 0);
        keep = 1'b1;
        for (int k = 0; k < 10; k++) begin
            idle(5);
            merge[3] = 1'b1; step();
        end
        chk(expired[3], "R5", "kept merges do not restart", expired[3], 1);
        keep = 1'b0;
        merge[3] = 1'b1; step();
        chk(!expired[3], "R5", "merge clears expired slot", expired[3], 0);
        rel[3] = 1'b1; step();
        merge[6] = 1'b1; step();
        chk(!expired[6], "R5", "merge into empty slot", expired[6], 0);

        // R9, R8, R3, R4: lowest index, release, allocate priority, saturation
        cur_req = "R9";
        sel = '0;
        idle(2);
        alloc = 8'b0100_1010; step();
        idle(2 * per(0) + 3);
        chk(expired == 8'b0100_1010 && idx == IW'(1), "R9", "lowest of three",
            {expired, idx}, {8'b0100_1010, IW'(1)});
        idle(20);
        chk(expired == 8'b0100_1010, "R4", "age saturates, stays expired", expired, 8'b0100_1010);
        cur_req = "R8";
        rel[1] = 1'b1; step();
        chk(!expired[1] && idx == IW'(3), "R8", "release drops slot 1",
            {expired[1], idx}, {1'b0, IW'(3)});
        cur_req = "R3";
        alloc[3] = 1'b1; rel[3] = 1'b1; step();
        chk(!expired[3] && idx == IW'(6), "R3", "alloc beats release",
            {expired[3], idx}, {1'b0, IW'(6)});
        idle(2 * per(0) + 2);
        chk(expired[3], "R3", "slot stays valid after tie", expired[3], 1);
        rel = 8'b0100_1000; step();
        chk(!any_exp && idx == '0, "R9", "nothing expired", {any_exp, idx}, 0);

        // R10: select changing every cycle suppresses programmed steps
        cur_req = "R10";
        sel = SW'(2);
        idle(2);
        alloc[0] = 1'b1; step();
        for (int k = 0; k < 100; k++) begin
            sel = (k % 2 == 0) ? SW'(3) : SW'(2);
            step();
        end
        chk(!expired[0], "R10", "no steps while select changes", expired[0], 0);
        sel = SW'(2);
        idle(2 * per(2) + 2);
        chk(expired[0], "R10", "ages once select is steady", expired[0], 1);
        rel[0] = 1'b1; step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule